// File: doc/BRIEF.md
# ECC Failure Blank-Page Qualifier

This block sits behind a NAND page-read ECC decoder and turns the decoder's raw failure flags into a final two-bit error code. An erased page holds nothing but 0xFF, and its spare bytes do not match what the decoder expects, so the decoder reports it as uncorrectable. The qualifier watches every byte of the data area and of the tag (spare) area as they stream out of the read path. It keeps a running AND of each area's bytes, and it withholds an area's failure when that area read back as all ones.

A read is opened with a one-cycle `page_start`. The bytes then arrive tagged with their area, and the final byte carries `byte_last`. At some point before, with or after the final byte, the decoder presents its summary on a one-cycle `flags_valid`. Once both the final byte and the flags have been taken in, the block raises `result_valid` for a single cycle with the code on `result`. An area that received no bytes during the read is never reported, which covers a spare-only read.

Top module: `ecc_blank_qualifier`

## Requirements
- R1: While reset is asserted and after its release, before any page completes, `result_valid` is 0 and `result` is 0.
- R2: When the global error input captured with the flags is 0, the result is 00, whatever the per-area failure flags and the byte values.
- R3: Bit 1 of `result` is set when the global error is 1, the data failure flag is 1, and at least one byte tagged as data (`byte_area` = 0) differs from 0xFF.
- R4: A data failure whose data bytes were all 0xFF is suppressed (bit 1 = 0).
- R5: Bit 0 of `result` is set when the global error is 1, the tag failure flag is 1, and at least one byte tagged as tag (`byte_area` = 1) differs from 0xFF.
- R6: A tag failure whose tag bytes were all 0xFF is suppressed (bit 0 = 0).
- R7: An area that received no bytes since `page_start` is never reported, even when its failure flag is set.
- R8: Both bits may be set together when both areas qualify.
- R9: `result_valid` is high for exactly one cycle. That cycle follows the clock edge that sampled the later of the final byte and `flags_valid`, and the edge may be one that sampled both. The result is the same whichever of the two comes first.
- R10: `page_start` clears both areas' byte history, the transfer marks and the captured flags, so nothing carries over from a previous page.
- R11: A decoder outcome with the global error set but neither area flag set (an error the decoder has already corrected) gives 00. A non-0xFF byte in an area whose flag is clear also gives 00.
- R12: After a page has reported, further final bytes or flag strobes produce no new `result_valid` until the next `page_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| page_start | input | 1 | One-cycle pulse that opens a new page read |
| byte_valid | input | 1 | A read byte is present |
| byte_area | input | 1 | Area of the byte: 0 data, 1 tag |
| byte_data | input | BYTE_W | Read byte |
| byte_last | input | 1 | Marks the final byte of the read |
| flags_valid | input | 1 | Decoder summary is present |
| ecc_any | input | 1 | Decoder saw any ECC error |
| data_fail | input | 1 | Data area uncorrectable |
| tag_fail | input | 1 | Tag area uncorrectable |
| result_valid | output | 1 | One-cycle result strobe |
| result | output | 2 | Bit 1 data error, bit 0 tag error |

## Verification
The result is due exactly one cycle after the completing edge, which is the edge that samples the later of the final byte and the decoder flags. The bench drives inputs on falling edges. It checks that `result_valid` is still low at the falling edge right after the last stimulus edge if the other event is still outstanding, high with the expected code one falling edge after completion, and low again one falling edge later. The three arrival orders are covered: flags first, flags last, and flags with the final byte. Each order has its own expected-strobe timing.

// File: rtl/ecc_blank_qualifier.sv
module ecc_blank_qualifier #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_start,
  input  logic              byte_valid,
  input  logic              byte_area,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              byte_last,
  input  logic              flags_valid,
  input  logic              ecc_any,
  input  logic              data_fail,
  input  logic              tag_fail,
  output logic              result_valid,
  output logic [1:0]        result
);

  localparam logic [BYTE_W-1:0] ERASED = {BYTE_W{1'b1}};
  localparam logic AREA_DATA = 1'b0;

  logic d_seen, t_seen, d_blank, t_blank;
  logic last_got, flags_got, reported;
  logic f_any, f_data, f_tag;
  logic res_v;
  logic [1:0] res_q;

  logic d_hit, t_hit, byte_erased;
  logic d_seen_n, t_seen_n, d_blank_n, t_blank_n;
  logic last_n, flags_n, rep_base;
  logic f_any_n, f_data_n, f_tag_n;
  logic fire;
  logic [1:0] code;

  assign byte_erased = (byte_data == ERASED);
  assign d_hit = byte_valid && (byte_area == AREA_DATA);
  assign t_hit = byte_valid && (byte_area != AREA_DATA);

  assign d_seen_n  = (page_start ? 1'b0 : d_seen) | d_hit;
  assign t_seen_n  = (page_start ? 1'b0 : t_seen) | t_hit;
  assign d_blank_n = (page_start ? 1'b1 : d_blank) & ~(d_hit & ~byte_erased);
  assign t_blank_n = (page_start ? 1'b1 : t_blank) & ~(t_hit & ~byte_erased);

  assign last_n   = (page_start ? 1'b0 : last_got) | (byte_valid & byte_last);
  assign flags_n  = (page_start ? 1'b0 : flags_got) | flags_valid;
  assign rep_base = page_start ? 1'b0 : reported;

  assign f_any_n  = flags_valid ? ecc_any   : (page_start ? 1'b0 : f_any);
  assign f_data_n = flags_valid ? data_fail : (page_start ? 1'b0 : f_data);
  assign f_tag_n  = flags_valid ? tag_fail  : (page_start ? 1'b0 : f_tag);

  assign fire = last_n & flags_n & ~rep_base;

  assign code[1] = f_any_n & f_data_n & d_seen_n & ~d_blank_n;
  assign code[0] = f_any_n & f_tag_n  & t_seen_n & ~t_blank_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_seen    <= 1'b0;
      t_seen    <= 1'b0;
      d_blank   <= 1'b1;
      t_blank   <= 1'b1;
      last_got  <= 1'b0;
      flags_got <= 1'b0;
      reported  <= 1'b0;
      f_any     <= 1'b0;
      f_data    <= 1'b0;
      f_tag     <= 1'b0;
      res_v     <= 1'b0;
      res_q     <= 2'b00;
    end else begin
      d_seen    <= d_seen_n;
      t_seen    <= t_seen_n;
      d_blank   <= d_blank_n;
      t_blank   <= t_blank_n;
      last_got  <= last_n;
      flags_got <= flags_n;
      reported  <= rep_base | fire;
      f_any     <= f_any_n;
      f_data    <= f_data_n;
      f_tag     <= f_tag_n;
      res_v     <= fire;
      if (fire) res_q <= code;
    end
  end

  assign result_valid = res_v;
  assign result       = res_q;

endmodule

// File: rtl/ecc_blank_qualifier_chk.sv
module ecc_blank_qualifier_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              page_start,
  input logic              byte_valid,
  input logic              byte_area,
  input logic [BYTE_W-1:0] byte_data,
  input logic              byte_last,
  input logic              flags_valid,
  input logic              ecc_any,
  input logic              result_valid,
  input logic [1:0]        result
);

  logic c_any, c_dseen, c_dbad, c_tbad, c_last, c_flags, c_rep;
  logic nonff;

  assign nonff = byte_valid && (byte_data != {BYTE_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_any <= 1'b0; c_dseen <= 1'b0; c_dbad <= 1'b0; c_tbad <= 1'b0;
      c_last <= 1'b0; c_flags <= 1'b0; c_rep <= 1'b0;
    end else if (page_start) begin
      c_any   <= flags_valid & ecc_any;
      c_dseen <= byte_valid & ~byte_area;
      c_dbad  <= nonff & ~byte_area;
      c_tbad  <= nonff & byte_area;
      c_last  <= byte_valid & byte_last;
      c_flags <= flags_valid;
      c_rep   <= 1'b0;
    end else begin
      if (flags_valid) c_any <= ecc_any;
      if (byte_valid && !byte_area) c_dseen <= 1'b1;
      if (nonff && !byte_area) c_dbad <= 1'b1;
      if (nonff && byte_area) c_tbad <= 1'b1;
      if (byte_valid && byte_last) c_last <= 1'b1;
      if (flags_valid) c_flags <= 1'b1;
      if (result_valid) c_rep <= 1'b1;
    end
  end

  assert_no_global_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && !c_any) |-> (result == 2'b00));
  assert_data_nonff_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && result[1]) |-> c_dbad);
  assert_tag_nonff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && result[0]) |-> c_tbad);
  assert_untransferred_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && result[1]) |-> c_dseen);
  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  assert_inputs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (c_last && c_flags));
  assert_single_report_R12: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> !c_rep);

endmodule

bind ecc_blank_qualifier ecc_blank_qualifier_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .page_start(page_start), .byte_valid(byte_valid),
  .byte_area(byte_area), .byte_data(byte_data), .byte_last(byte_last),
  .flags_valid(flags_valid), .ecc_any(ecc_any),
  .result_valid(result_valid), .result(result)
);

// File: tb/tb_ecc_blank_qualifier.sv
module tb_ecc_blank_qualifier;
  localparam int BW = 8;
  localparam int ND = 8;
  localparam int NT = 6;
  localparam int NV = 10;

  // {any, dfail, tfail, dbad, tbad, hasdata, order[1:0], exp[1:0]}
  // order: 0 flags before bytes, 1 flags after last byte, 2 flags with last byte
  localparam logic [9:0] VECS [NV] = '{
    10'b1_0_0_0_0_1_00_00,  // R11 corrected
    10'b0_1_1_1_1_1_01_00,  // R2
    10'b1_1_0_1_0_1_01_10,  // R3
    10'b1_1_0_0_0_1_10_00,  // R4 R10
    10'b1_0_1_0_1_1_00_01,  // R5
    10'b1_0_1_0_0_1_01_00,  // R6
    10'b1_1_1_1_1_1_10_11,  // R8
    10'b1_1_1_0_1_0_01_01,  // R7 spare-only
    10'b1_0_0_1_1_1_00_00,  // R11 flags clear
    10'b1_1_1_1_0_1_00_10   // R3 R6
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic page_start = 0, byte_valid = 0, byte_area = 0, byte_last = 0;
  logic [BW-1:0] byte_data = '0;
  logic flags_valid = 0, ecc_any = 0, data_fail = 0, tag_fail = 0;
  logic result_valid;
  logic [1:0] result;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ecc_blank_qualifier #(.BYTE_W(BW)) dut (
    .clk(clk), .rst_n(rst_n), .page_start(page_start), .byte_valid(byte_valid),
    .byte_area(byte_area), .byte_data(byte_data), .byte_last(byte_last),
    .flags_valid(flags_valid), .ecc_any(ecc_any), .data_fail(data_fail),
    .tag_fail(tag_fail), .result_valid(result_valid), .result(result)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_flags(input logic a, input logic d, input logic t);
    flags_valid = 1; ecc_any = a; data_fail = d; tag_fail = t;
  endtask

  task automatic run_page(input logic [9:0] v, input string req);
    int total, nd;
    nd = v[4] ? ND : 0;
    total = nd + NT;
    @(negedge clk) page_start = 1;
    @(negedge clk) page_start = 0;
    if (v[3:2] == 2'd0) begin
      set_flags(v[9], v[8], v[7]);
      @(negedge clk) flags_valid = 0;
    end
    for (int i = 0; i < total; i++) begin
      byte_valid = 1;
      byte_area  = (i >= nd);
      byte_data  = 8'hFF;
      if (i < nd && v[6] && i == 3) byte_data = 8'h5A;
      if (i == total - 1 && v[5]) byte_data = 8'hA5;
      byte_last  = (i == total - 1);
      if (i == total - 1 && v[3:2] == 2'd2) set_flags(v[9], v[8], v[7]);
      @(negedge clk);
      if (i < total - 1) chk({req, " R9 no early strobe"}, result_valid, 0);
    end
    byte_valid = 0; byte_last = 0; flags_valid = 0;
    if (v[3:2] == 2'd1) begin
      chk({req, " R9 waits for flags"}, result_valid, 0);
      set_flags(v[9], v[8], v[7]);
      @(negedge clk) flags_valid = 0;
    end
    chk({req, " R9 strobe"}, result_valid, 1);
    chk({req, " code"}, result, v[1:0]);
    @(negedge clk);
    chk({req, " R9 one cycle"}, result_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", result_valid, 0);
    chk("R1 reset result", result, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 idle valid", result_valid, 0);
    chk("R1 idle result", result, 0);

    for (int k = 0; k < NV; k++) run_page(VECS[k], $sformatf("vec%0d", k));

    // R12: no second report without page_start
    byte_valid = 1; byte_area = 0; byte_data = 8'h00; byte_last = 1;
    set_flags(1, 1, 1);
    @(negedge clk);
    byte_valid = 0; byte_last = 0; flags_valid = 0;
    chk("R12 no re-report", result_valid, 0);
    @(negedge clk);
    chk("R12 still quiet", result_valid, 0);

    // R10: dirty previous page must not leak into a blank page
    run_page(10'b1_1_1_1_1_1_00_11, "R10 dirty page");
    run_page(10'b1_1_1_0_0_1_01_00, "R10 blank page after dirty");

    // R1: reset in the middle of a page drops it
    @(negedge clk) page_start = 1;
    @(negedge clk) page_start = 0; byte_valid = 1; byte_data = 8'h11; byte_area = 0;
    @(negedge clk) byte_valid = 0; rst_n = 0;
    @(negedge clk) rst_n = 1;
    set_flags(1, 1, 0);
    @(negedge clk) flags_valid = 0;
    chk("R1 reset clears progress", result_valid, 0);
    run_page(10'b1_1_0_0_0_1_00_00, "R1 after reset blank");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule